// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This block runs a single conversion on an external multi-channel analog-to-digital converter by stepping two 16-bit control registers through a fixed order of writes. A client presents a logical channel (0 to 17) and a timing mode, immediate or timed. The sequencer works out which bank and mux variant the channel needs and programs the configuration fields. It then arms the trigger in the order that mode requires and waits for the converter's done pulse. Each write appears as a new value on the `ctrl1`/`ctrl2` outputs, one write per clock; a bus bridge outside the block carries them to the converter.

A done pulse that never arrives is handled by timing out, forcing the trigger off again and re-running the setup. The number of attempts is bounded. When the pulse does arrive, the trigger is disabled and the block holds the result slot index until the client acknowledges that it has read the data. Both registers are then returned to their idle patterns and one completion pulse is emitted, with an error flag if every attempt ran out.

Top module: `adc_req_seq`

## Requirements
- R1: Channels 0–7 leave `ctrl1[3]` and `ctrl1[2]` clear and use result slot = channel. Channels 8–15 set `ctrl1[3]` (bank select) and use slot = channel − 8. Channel 16 sets `ctrl1[2]` (remux) with slot 1, and channel 17 sets `ctrl1[2]` with slot 6. `ctrl1[3]` and `ctrl1[2]` are never set together.
- R2: In immediate mode, `ctrl2[5]` (trigger disable) is 1 in the cycle before `ctrl2[12]` (start conversion) rises. At the trigger, `ctrl1 = 0x9000 | bank/remux bits` and `ctrl2 = 0x1136`, with bit 6 added for channel 0.
- R3: In timed mode, `ctrl2[13]` (one-shot) is set first and `ctrl2[5]` is cleared in a later cycle. The `TIMED_C1` bits (default 0x0480) are ORed into `ctrl1` and the `TIMED_C2` bits (default 0x0200) into `ctrl2`.
- R4: For channel 0 only, `ctrl2[6]` (thermistor bias) is set at least `BIAS_CYC` cycles before the trigger. It stays clear for every other channel.
- R5: If no `conv_done` arrives within `TIMEOUT_TICKS` ticks of `TICK_DIV` clocks after a trigger, the block sets `ctrl2[5]`, repeats the setup and triggers again.
- R6: At most `MAX_TRY` triggers are issued per request. After the last one times out, the block restores the defaults and pulses `fin` together with `fin_err` = 1.
- R7: On `conv_done` the block sets `ctrl2[5]`, then holds `res_ready` high and `res_slot` stable until `rd_ack`.
- R8: At completion, `ctrl1` returns to 0x9004 and then `ctrl2` returns to 0x0136. `fin` pulses for one cycle in the cycle the second write appears, with `fin_err` = 0 on success.
- R9: A request is accepted only when `busy` = 0 and the channel is at most 17. `busy` stays high from acceptance until the defaults are restored. Any other request is ignored.
- R10: After reset, `busy`, `res_ready`, `fin` and `fin_err` are 0, `ctrl1` = 0x9004 and `ctrl2` = 0x0136.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_chan | input | 5 | Logical channel number |
| req_timed | input | 1 | 1 = timed trigger, 0 = immediate |
| conv_done | input | 1 | Converter done pulse |
| rd_ack | input | 1 | Client has read the result |
| busy | output | 1 | Request in progress |
| res_ready | output | 1 | Conversion finished, awaiting read |
| res_slot | output | 3 | Result slot index for the read |
| fin | output | 1 | One-cycle completion pulse |
| fin_err | output | 1 | Completion ended in timeout |
| ctrl1 | output | 16 | Control register 1 image |
| ctrl2 | output | 16 | Control register 2 image |

## Verification
The hardest case to reach is a converter that loses its done pulse on several consecutive attempts, and the exhaustion of the retry budget in particular. From the ports, that only occurs when the trigger is repeatedly observed and never answered. The bench includes a converter model that recognises each trigger from the register images and swallows a chosen number of done pulses before answering. Random requests use drop counts from 0 to 2, and directed cases drop exactly `MAX_TRY` − 1 and `MAX_TRY` pulses, so the last-try success and the exhaustion paths are both exercised.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int REG_W       = 16;
   localparam int CHAN_W      = 5;
   localparam int SLOT_W      = 3;
   localparam int LAST_CHAN   = 17;

   localparam int C1_BANK     = 3;
   localparam int C1_REMUX    = 2;
   localparam int C2_TRGDIS   = 5;
   localparam int C2_BIAS     = 6;
   localparam int C2_START    = 12;
   localparam int C2_ONESHOT  = 13;

   localparam logic [REG_W-1:0] C1_DEFAULT      = 16'h9004;
   localparam logic [REG_W-1:0] C2_DEFAULT      = 16'h0136;
   localparam logic [REG_W-1:0] C1_CFG_MASK     = 16'h4FFE;
   localparam logic [REG_W-1:0] C2_CFG_MASK     = 16'h3E40;
   localparam logic [REG_W-1:0] C1_TIMING_FIELD = 16'h0F80;
   localparam logic [REG_W-1:0] C2_TIMING_FIELD = 16'h0E00;

   typedef enum logic [3:0] {
      ST_IDLE, ST_BIAS, ST_BIAS_WAIT, ST_CFG1, ST_CFG2, ST_TRIG_A, ST_TRIG_B,
      ST_WAIT, ST_RECOVER, ST_DONE_DIS, ST_HOLD, ST_REST1, ST_REST2
   } seq_state_t;

   typedef struct packed {
      logic [SLOT_W-1:0] slot;
      logic              bank;
      logic              remux;
      logic              bias;
      logic              ok;
   } chan_info_t;

endpackage

// File: rtl/adc_chan_decode.sv
module adc_chan_decode
   import adc_seq_pkg::*;
(
   input  logic [CHAN_W-1:0] chan,
   output chan_info_t        info
);
   localparam int BANK_SIZE = 1 << SLOT_W;
   localparam logic [SLOT_W-1:0] REMUX_A_SLOT = SLOT_W'(1);
   localparam logic [SLOT_W-1:0] REMUX_B_SLOT = SLOT_W'(6);

   always_comb begin
      info       = '0;
      info.ok    = (int'(chan) <= LAST_CHAN);
      info.bias  = (chan == '0);
      if (int'(chan) < BANK_SIZE) begin
         info.slot = chan[SLOT_W-1:0];
      end else if (int'(chan) < 2 * BANK_SIZE) begin
         info.slot = SLOT_W'(int'(chan) - BANK_SIZE);
         info.bank = 1'b1;
      end else if (int'(chan) == 2 * BANK_SIZE) begin
         info.slot  = REMUX_A_SLOT;
         info.remux = 1'b1;
      end else if (int'(chan) == 2 * BANK_SIZE + 1) begin
         info.slot  = REMUX_B_SLOT;
         info.remux = 1'b1;
      end
   end
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
   parameter int TICK_DIV = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (TICK_DIV == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_divider
         localparam int DIV_W = $clog2(TICK_DIV);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                      div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_LAST);
      end
   endgenerate
endmodule

// File: rtl/adc_try_ctr.sv
module adc_try_ctr #(
   parameter int MAX_TRY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic bump,
   output logic last
);
   localparam int TRY_W = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;
   localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRY - 1);

   generate
      if (MAX_TRY < 1) begin : g_bad_try
         $error("MAX_TRY must be at least 1");
      end
   endgenerate

   logic [TRY_W-1:0] used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        used_q <= '0;
      else if (clear)                    used_q <= '0;
      else if (bump && used_q != TRY_LAST) used_q <= used_q + 1'b1;
   end

   assign last = (used_q == TRY_LAST);
endmodule

// File: rtl/adc_req_seq.sv
module adc_req_seq
   import adc_seq_pkg::*;
#(
   parameter int               TICK_DIV      = 100000,
   parameter int               TIMEOUT_TICKS = 50,
   parameter int               MAX_TRY       = 5,
   parameter int               BIAS_CYC      = 90000,
   parameter logic [REG_W-1:0] TIMED_C1      = 16'h0480,
   parameter logic [REG_W-1:0] TIMED_C2      = 16'h0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CHAN_W-1:0] req_chan,
   input  logic              req_timed,
   input  logic              conv_done,
   input  logic              rd_ack,
   output logic              busy,
   output logic              res_ready,
   output logic [SLOT_W-1:0] res_slot,
   output logic              fin,
   output logic              fin_err,
   output logic [REG_W-1:0]  ctrl1,
   output logic [REG_W-1:0]  ctrl2
);
   localparam int TO_W   = $clog2(TIMEOUT_TICKS + 1);
   localparam int BIAS_W = $clog2(BIAS_CYC + 1);
   localparam logic [TO_W-1:0]   TO_LAST   = TO_W'(TIMEOUT_TICKS - 1);
   localparam logic [BIAS_W-1:0] BIAS_LAST = BIAS_W'(BIAS_CYC - 1);

   generate
      if (TIMEOUT_TICKS < 1) begin : g_bad_to
         $error("TIMEOUT_TICKS must be at least 1");
      end
      if (BIAS_CYC < 1) begin : g_bad_bias
         $error("BIAS_CYC must be at least 1");
      end
      if ((TIMED_C1 & ~C1_TIMING_FIELD) != '0) begin : g_bad_c1
         $error("TIMED_C1 outside the ctrl1 timing field");
      end
      if ((TIMED_C2 & ~C2_TIMING_FIELD) != '0) begin : g_bad_c2
         $error("TIMED_C2 outside the ctrl2 timing field");
      end
   endgenerate

   chan_info_t  dec_info;
   chan_info_t  act_q;
   logic        timed_q;
   logic        err_q;
   logic        fin_q;
   seq_state_t  st_q;
   logic [TO_W-1:0]   to_q;
   logic [BIAS_W-1:0] bias_q;
   logic [REG_W-1:0]  c1_q, c2_q;
   logic        tick;
   logic        try_clear, try_bump, try_last;
   logic        accept;

   adc_chan_decode u_dec (
      .chan (req_chan),
      .info (dec_info)
   );

   adc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   adc_try_ctr #(.MAX_TRY(MAX_TRY)) u_try (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (try_clear),
      .bump  (try_bump),
      .last  (try_last)
   );

   assign accept    = (st_q == ST_IDLE) && req_valid && dec_info.ok;
   assign try_clear = accept;
   assign try_bump  = (st_q == ST_RECOVER) && !try_last;

   // Configuration words for the current request
   logic [REG_W-1:0] cfg1_word, cfg2_word;
   always_comb begin
      cfg1_word = '0;
      cfg1_word[C1_BANK]  = act_q.bank;
      cfg1_word[C1_REMUX] = act_q.remux;
      if (timed_q) cfg1_word = cfg1_word | TIMED_C1;
      cfg2_word = '0;
      cfg2_word[C2_BIAS] = act_q.bias;
      if (timed_q) cfg2_word = cfg2_word | TIMED_C2;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         act_q   <= '0;
         timed_q <= 1'b0;
         err_q   <= 1'b0;
         fin_q   <= 1'b0;
         to_q    <= '0;
         bias_q  <= '0;
         c1_q    <= C1_DEFAULT;
         c2_q    <= C2_DEFAULT;
      end else begin
         fin_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  act_q   <= dec_info;
                  timed_q <= req_timed;
                  err_q   <= 1'b0;
                  st_q    <= dec_info.bias ? ST_BIAS : ST_CFG1;
               end
            end
            ST_BIAS: begin
               c2_q[C2_BIAS] <= 1'b1;
               bias_q        <= '0;
               st_q          <= ST_BIAS_WAIT;
            end
            ST_BIAS_WAIT: begin
               if (bias_q == BIAS_LAST) st_q <= ST_CFG1;
               else                     bias_q <= bias_q + 1'b1;
            end
            ST_CFG1: begin
               c1_q <= (c1_q & ~C1_CFG_MASK) | cfg1_word;
               st_q <= ST_CFG2;
            end
            ST_CFG2: begin
               c2_q <= (c2_q & ~C2_CFG_MASK) | cfg2_word;
               st_q <= ST_TRIG_A;
            end
            ST_TRIG_A: begin
               if (timed_q) c2_q[C2_ONESHOT] <= 1'b1;
               else         c2_q[C2_TRGDIS]  <= 1'b1;
               st_q <= ST_TRIG_B;
            end
            ST_TRIG_B: begin
               if (timed_q) c2_q[C2_TRGDIS] <= 1'b0;
               else         c2_q[C2_START]  <= 1'b1;
               to_q <= '0;
               st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (conv_done) begin
                  st_q <= ST_DONE_DIS;
               end else if (tick) begin
                  if (to_q == TO_LAST) st_q <= ST_RECOVER;
                  else                 to_q <= to_q + 1'b1;
               end
            end
            ST_RECOVER: begin
               c2_q[C2_TRGDIS] <= 1'b1;
               if (try_last) begin
                  err_q <= 1'b1;
                  st_q  <= ST_REST1;
               end else begin
                  st_q  <= act_q.bias ? ST_BIAS : ST_CFG1;
               end
            end
            ST_DONE_DIS: begin
               c2_q[C2_TRGDIS] <= 1'b1;
               st_q <= ST_HOLD;
            end
            ST_HOLD: begin
               if (rd_ack) st_q <= ST_REST1;
            end
            ST_REST1: begin
               c1_q <= C1_DEFAULT;
               st_q <= ST_REST2;
            end
            ST_REST2: begin
               c2_q  <= C2_DEFAULT;
               fin_q <= 1'b1;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign res_ready = (st_q == ST_HOLD);
   assign res_slot  = act_q.slot;
   assign fin       = fin_q;
   assign fin_err   = fin_q & err_q;
   assign ctrl1     = c1_q;
   assign ctrl2     = c2_q;

endmodule

// File: rtl/adc_req_seq_chk.sv
module adc_req_seq_chk
   import adc_seq_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             res_ready,
   input logic             fin,
   input logic             fin_err,
   input logic [REG_W-1:0] ctrl1,
   input logic [REG_W-1:0] ctrl2
);
   AST_BANK_REMUX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl1[C1_BANK] && ctrl1[C1_REMUX])); // R1
   AST_IMM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl2[C2_START]) |-> $past(ctrl2[C2_TRGDIS])); // R2
   AST_TIMED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl2[C2_TRGDIS]) |-> $past(ctrl2[C2_ONESHOT])); // R3
   AST_READY_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      res_ready |-> ctrl2[C2_TRGDIS]); // R7
   AST_IDLE_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ctrl1 == C1_DEFAULT && ctrl2 == C2_DEFAULT)); // R8
   AST_FIN_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (!busy && $past(busy))); // R9
   AST_ERR_ON_FIN: assert property (@(posedge clk) disable iff (!rst_n)
      fin_err |-> fin); // R6
endmodule

bind adc_req_seq adc_req_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .res_ready (res_ready),
   .fin       (fin),
   .fin_err   (fin_err),
   .ctrl1     (ctrl1),
   .ctrl2     (ctrl2)
);

// File: tb/tb_adc_req_seq.sv
module tb_adc_req_seq;
   localparam int TICK_DIV = 10;
   localparam int TO_TICKS = 5;
   localparam int MAX_TRY  = 5;
   localparam int BIAS_CYC = 8;
   localparam int DONE_LAT = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [4:0] req_chan = '0;
   logic req_timed = 1'b0;
   logic conv_done = 1'b0;
   logic rd_ack = 1'b0;
   logic busy, res_ready, fin, fin_err;
   logic [2:0] res_slot;
   logic [15:0] ctrl1, ctrl2;

   int n_chk = 0;
   int n_fail = 0;

   // converter model state
   int trig_cnt, drop_left, lat_cnt, bias_cnt, bias_at_trig;
   logic [15:0] seen_c1, seen_c2, seen_prev, prev_c2;

   always #5 clk = ~clk;

   adc_req_seq #(
      .TICK_DIV(TICK_DIV), .TIMEOUT_TICKS(TO_TICKS), .MAX_TRY(MAX_TRY),
      .BIAS_CYC(BIAS_CYC), .TIMED_C1(16'h0480), .TIMED_C2(16'h0200)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_timed(req_timed), .conv_done(conv_done), .rd_ack(rd_ack),
      .busy(busy), .res_ready(res_ready), .res_slot(res_slot), .fin(fin),
      .fin_err(fin_err), .ctrl1(ctrl1), .ctrl2(ctrl2)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_c1(int ch, bit t);
      logic [15:0] v = 16'h9000;
      if (ch >= 8 && ch <= 15) v |= 16'h0008;
      if (ch >= 16) v |= 16'h0004;
      if (t) v |= 16'h0480;
      return v;
   endfunction

   function automatic logic [15:0] exp_base2(int ch, bit t);
      logic [15:0] v = 16'h0136;
      if (ch == 0) v |= 16'h0040;
      if (t) v |= 16'h0200;
      return v;
   endfunction

   function automatic logic [15:0] exp_trig2(int ch, bit t);
      return t ? ((exp_base2(ch, t) | 16'h2000) & ~16'h0020) : (exp_base2(ch, t) | 16'h1000);
   endfunction

   function automatic logic [15:0] exp_prev2(int ch, bit t);
      return t ? (exp_base2(ch, t) | 16'h2000) : exp_base2(ch, t);
   endfunction

   function automatic int exp_slot(int ch);
      if (ch < 8) return ch;
      if (ch < 16) return ch - 8;
      return (ch == 16) ? 1 : 6;
   endfunction

   // converter model: detects triggers and answers, optionally dropping pulses
   initial begin
      trig_cnt = 0; drop_left = 0; lat_cnt = 0; bias_cnt = 0; bias_at_trig = 0;
      prev_c2 = 16'h0136; seen_c1 = '0; seen_c2 = '0; seen_prev = '0;
      forever begin
         @(negedge clk);
         conv_done = 1'b0;
         if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) conv_done = 1'b1;
         end
         if (busy && ((ctrl2[12] && !prev_c2[12]) || (ctrl2[13] && !ctrl2[5] && prev_c2[5]))) begin
            trig_cnt++;
            seen_c1 = ctrl1; seen_c2 = ctrl2; seen_prev = prev_c2;
            bias_at_trig = bias_cnt;
            if (drop_left > 0) drop_left--;
            else lat_cnt = DONE_LAT;
         end
         if (busy && ctrl2[6]) bias_cnt++;
         prev_c2 = ctrl2;
      end
   end

   task automatic run_req(input int ch, input bit t, input int drops, input bit intrude);
      bit got_ready = 1'b0;
      int exp_trigs = (drops + 1 > MAX_TRY) ? MAX_TRY : drops + 1;
      bit exp_err = (drops >= MAX_TRY);
      @(negedge clk);
      trig_cnt = 0; bias_cnt = 0; drop_left = drops; lat_cnt = 0;
      req_valid = 1'b1; req_chan = 5'(ch); req_timed = t;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 1);
      for (int cyc = 0; cyc < 4000; cyc++) begin
         if (fin) break;
         if (intrude && cyc == 3) begin
            req_valid = 1'b1; req_chan = 5'((ch + 3) % 18); req_timed = ~t;
         end else begin
            req_valid = 1'b0;
         end
         if (res_ready && !rd_ack) begin
            got_ready = 1'b1;
            chk(res_slot == 3'(exp_slot(ch)), "R1 slot", 32'(res_slot), 32'(exp_slot(ch)));
            chk(ctrl2[5] === 1'b1, "R7 trigger disabled on done", 32'(ctrl2[5]), 1);
            rd_ack = 1'b1;
         end else begin
            rd_ack = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0; rd_ack = 1'b0;
      chk(fin === 1'b1, "R8 fin pulse", 32'(fin), 1);
      chk(fin_err === exp_err, "R6 error flag", 32'(fin_err), 32'(exp_err));
      chk(got_ready === !exp_err, "R7 ready seen", 32'(got_ready), 32'(!exp_err));
      chk(busy === 1'b0, "R9 busy cleared", 32'(busy), 0);
      chk(ctrl1 == 16'h9004, "R8 ctrl1 default", 32'(ctrl1), 32'h9004);
      chk(ctrl2 == 16'h0136, "R8 ctrl2 default", 32'(ctrl2), 32'h0136);
      chk(trig_cnt == exp_trigs, "R5 R6 trigger count", 32'(trig_cnt), 32'(exp_trigs));
      chk(seen_c1 == exp_c1(ch, t), "R1 R3 ctrl1 at trigger", 32'(seen_c1), 32'(exp_c1(ch, t)));
      chk(seen_c2 == exp_trig2(ch, t), t ? "R3 ctrl2 at trigger" : "R2 ctrl2 at trigger",
          32'(seen_c2), 32'(exp_trig2(ch, t)));
      chk(seen_prev == exp_prev2(ch, t), t ? "R3 order" : "R2 order",
          32'(seen_prev), 32'(exp_prev2(ch, t)));
      if (ch == 0)
         chk(bias_at_trig >= BIAS_CYC, "R4 bias settle", 32'(bias_at_trig), BIAS_CYC);
      @(negedge clk);
      chk(fin === 1'b0, "R8 fin one cycle", 32'(fin), 0);
   endtask

   task automatic try_bad(input int ch);
      @(negedge clk);
      req_valid = 1'b1; req_chan = 5'(ch); req_timed = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0, "R9 out-of-range ignored", 32'(busy), 0);
      chk(ctrl1 == 16'h9004 && ctrl2 == 16'h0136, "R9 regs untouched", 32'({ctrl1, ctrl2}), 32'h90040136);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed = 32'h5eed;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && res_ready === 1'b0 && fin === 1'b0 && fin_err === 1'b0,
          "R10 reset outputs", 32'({busy, res_ready, fin, fin_err}), 0);
      chk(ctrl1 == 16'h9004 && ctrl2 == 16'h0136, "R10 reset regs", 32'({ctrl1, ctrl2}), 32'h90040136);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // directed corners
      run_req(0, 1'b0, 0, 1'b0);           // R4 bias, immediate
      run_req(0, 1'b1, 1, 1'b0);           // R4 bias with retry, timed
      run_req(7, 1'b0, 0, 1'b0);           // R1 last of bank 0
      run_req(8, 1'b0, 0, 1'b0);           // R1 first of bank 1
      run_req(15, 1'b1, 0, 1'b0);          // R1 last of bank 1
      run_req(16, 1'b0, 0, 1'b0);          // R1 remux A
      run_req(17, 1'b1, 0, 1'b0);          // R1 remux B
      run_req(6, 1'b0, MAX_TRY - 1, 1'b0); // R5 success on final try
      run_req(3, 1'b0, MAX_TRY, 1'b0);     // R6 exhausted, immediate
      run_req(11, 1'b1, MAX_TRY, 1'b0);    // R6 exhausted, timed
      run_req(5, 1'b0, 0, 1'b1);           // R9 request while busy ignored
      try_bad(18);
      try_bad(31);
      // random mix
      for (int i = 0; i < 24; i++) begin
         int ch = $urandom % 18;
         bit t = 1'($urandom % 2);
         int dr = ($urandom % 4 == 3) ? 2 : int'($urandom % 2);
         run_req(ch, t, dr, 1'($urandom % 4 == 0));
      end
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule